// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a 32-bit register file and a word-wide data memory. It takes one load or store instruction word and the value of its base register. From these it forms the effective address and the word address for memory, and it returns the register indices it needs. For stores it places the register data into the correct byte lanes and raises the matching byte enables. For loads it picks the addressed byte, halfword or word out of the memory read word and then sign-extends or zero-extends it to 32 bits for write-back.

The block is purely combinational and performs one access per evaluation. A static `big_end` input sets which end of the word sits at the lowest byte address. In little-endian mode the least significant byte of a word sits at the lowest byte address. In big-endian mode the most significant byte sits there. A halfword access that is not halfword aligned, or a word access that is not word aligned, raises `misalign` and blocks the access. Every opcode that is not a memory opcode leaves the memory side and the register write-back side idle.

Top module: `lsu_align_unit`

## Requirements
- R1: Only opcodes 0x20 (signed byte load), 0x24 (unsigned byte load), 0x21 (signed half load), 0x25 (unsigned half load), 0x23 (word load), 0x28 (byte store), 0x29 (half store) and 0x2b (word store) are memory operations. Any other opcode drives `mem_be`=0, `mem_we`=0, `mem_re`=0, `load_wr`=0, `misalign`=0 and `load_val`=0. `mem_we` and `mem_re` are never high together.
- R2: The instruction fields are opcode [31:26], base register index [25:21], data register index [20:16] and a 16-bit offset [15:0]. `eff_addr` equals `base_val` plus the sign-extended offset, modulo 2^32. `mem_addr` equals `eff_addr` with bits [1:0] cleared.
- R3: Byte lane k means bits [8k+7:8k]. A byte access uses lane `eff_addr[1:0]` when `big_end`=0 and lane 3−`eff_addr[1:0]` when `big_end`=1. A byte store sets exactly that one bit of `mem_be` and drives the low source byte into all four lanes of `mem_wdata`.
- R4: A halfword store sets `mem_be` to 4'b1100 when `eff_addr[1]` XOR `big_end` is 1, and to 4'b0011 otherwise. It drives the low source halfword into both halves. A word store sets `mem_be`=4'b1111 and drives the source value unchanged. Every aligned store raises `mem_we`.
- R5: Signed byte and halfword loads sign-extend the selected value to 32 bits. Unsigned byte and halfword loads zero-extend it. Halfword lane order follows R3 byte by byte.
- R6: A word load returns `mem_rdata` unchanged in both endian modes. Every aligned load raises `mem_re` and `load_wr`.
- R7: A halfword access with `eff_addr[0]`=1, or a word access with `eff_addr[1:0]`≠0, raises `misalign`. It also forces `mem_be`=0, `mem_we`=0, `mem_re`=0, `load_wr`=0 and `load_val`=0. A byte access never raises `misalign`.
- R8: A store followed by a load of the same size and address returns the stored value, extended as in R5, in either endian mode. After the word 0x00000005 is stored at address 8, a byte load returns 5 from address 11 in big-endian mode and from address 8 in little-endian mode.
- R9: `base_idx` and `data_idx` always present instruction bits [25:21] and [20:16].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Load/store instruction word |
| base_val | input | 32 | Value read from the base register |
| src_val | input | 32 | Value read from the data register (store source) |
| mem_rdata | input | 32 | Word read from memory at `mem_addr` |
| big_end | input | 1 | 1 = big-endian byte order, 0 = little-endian |
| base_idx | output | 5 | Base register index for the register file |
| data_idx | output | 5 | Data register index (store source or load destination) |
| eff_addr | output | 32 | Effective byte address |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_be | output | 4 | Byte-lane write enables |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read request |
| load_val | output | 32 | Extended load result |
| load_wr | output | 1 | Register write-back enable for loads |
| misalign | output | 1 | Misaligned halfword or word access |

## Verification
The block holds no state, so any wrong lane choice, extension or enable shows at the ports in the same evaluation that carries the instruction. A wrong byte-enable or data lane on a store shows up later. It corrupts the memory image, and the next load of any byte it touched returns the wrong value, so read-back after store is the main way to detect it. A decode that treats a non-memory opcode as a store is seen at once as a raised `mem_we` or `mem_be`.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the load/store alignment unit.
// Assumes a 32-bit architectural word made of four byte lanes.
package lsu_pkg;

    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int LANE_W  = $clog2(LANES);
    localparam int HALF_W  = WORD_W / 2;

    localparam logic [5:0] OPC_LDB  = 6'h20;
    localparam logic [5:0] OPC_LDBU = 6'h24;
    localparam logic [5:0] OPC_LDH  = 6'h21;
    localparam logic [5:0] OPC_LDHU = 6'h25;
    localparam logic [5:0] OPC_LDW  = 6'h23;
    localparam logic [5:0] OPC_STB  = 6'h28;
    localparam logic [5:0] OPC_STH  = 6'h29;
    localparam logic [5:0] OPC_STW  = 6'h2b;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_HALF = 2'd2,
        SZ_WORD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic      is_load;
        logic      is_store;
        logic      sign_ext;
        acc_size_e size;
    } acc_ctl_t;

endpackage

// File: rtl/lsu_decode.sv
`timescale 1ns/1ps
// Module: lsu_decode
// Turns the 6-bit opcode into access controls (direction, size, extension).
// Assumes unknown opcodes are not memory operations and yield all-zero controls.
module lsu_decode
    import lsu_pkg::*;
(
    input  logic [5:0] opcode,
    output acc_ctl_t   ctl
);

    // Opcode lookup into direction, width and extension kind.
    always_comb begin
        ctl = '{is_load: 1'b0, is_store: 1'b0, sign_ext: 1'b0, size: SZ_NONE};
        unique case (opcode)
            OPC_LDB:  ctl = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b1, size: SZ_BYTE};
            OPC_LDBU: ctl = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_BYTE};
            OPC_LDH:  ctl = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b1, size: SZ_HALF};
            OPC_LDHU: ctl = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_HALF};
            OPC_LDW:  ctl = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_WORD};
            OPC_STB:  ctl = '{is_load: 1'b0, is_store: 1'b1, sign_ext: 1'b0, size: SZ_BYTE};
            OPC_STH:  ctl = '{is_load: 1'b0, is_store: 1'b1, sign_ext: 1'b0, size: SZ_HALF};
            OPC_STW:  ctl = '{is_load: 1'b0, is_store: 1'b1, sign_ext: 1'b0, size: SZ_WORD};
            default:  ;
        endcase
    end

endmodule

// File: rtl/lsu_addr_gen.sv
`timescale 1ns/1ps
// Module: lsu_addr_gen
// Forms the effective and word addresses and derives the byte lane, the
// halfword side and the misalignment flag from the low address bits.
// Assumes an offset narrower than the address, sign-extended before the add.
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base_val,
    input  logic [OFF_W-1:0]  offset,
    input  acc_size_e         size,
    input  logic              big_end,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] word_addr,
    output logic [LANE_W-1:0] lane,
    output logic              half_hi,
    output logic              misalign
);

    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    // Sign-extend the offset and add it to the base register value.
    always_comb begin
        off_ext   = {{EXT_W{offset[OFF_W-1]}}, offset};
        eff_addr  = base_val + off_ext;
        word_addr = {eff_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    end

    // Lane selection; big-endian mirrors the lane index within the word.
    always_comb begin
        lane    = eff_addr[LANE_W-1:0] ^ {LANE_W{big_end}};
        half_hi = eff_addr[LANE_W-1] ^ big_end;
    end

    // Alignment check per access size.
    always_comb begin
        unique case (size)
            SZ_HALF: misalign = eff_addr[0];
            SZ_WORD: misalign = |eff_addr[LANE_W-1:0];
            default: misalign = 1'b0;
        endcase
    end

endmodule

// File: rtl/lsu_store_lane.sv
`timescale 1ns/1ps
// Module: lsu_store_lane
// Places store data into byte lanes and raises the byte enables.
// Assumes the data is replicated across lanes; only enabled lanes are written.
module lsu_store_lane
    import lsu_pkg::*;
(
    input  logic              is_store,
    input  acc_size_e         size,
    input  logic [LANE_W-1:0] lane,
    input  logic              half_hi,
    input  logic              misalign,
    input  logic [WORD_W-1:0] src_val,
    output logic [WORD_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic              we
);

    logic go;

    // Write strobe: an aligned store only.
    always_comb begin
        go = is_store & ~misalign;
        we = go;
    end

    // Replicate the source value to the access width across the word.
    always_comb begin
        unique case (size)
            SZ_BYTE: wdata = {LANES{src_val[7:0]}};
            SZ_HALF: wdata = {2{src_val[HALF_W-1:0]}};
            default: wdata = src_val;
        endcase
    end

    // One enable per lane, set by size and position.
    for (genvar k = 0; k < LANES; k++) begin : g_be
        localparam logic [LANE_W-1:0] KL = LANE_W'(k);
        localparam logic              KH = (k >= LANES / 2);
        always_comb begin
            unique case (size)
                SZ_BYTE: be[k] = go & (lane == KL);
                SZ_HALF: be[k] = go & (half_hi == KH);
                SZ_WORD: be[k] = go;
                default: be[k] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/lsu_load_lane.sv
`timescale 1ns/1ps
// Module: lsu_load_lane
// Selects the addressed byte/halfword/word from the read word and extends it.
// Assumes the read word is the one at the word-aligned address this cycle.
module lsu_load_lane
    import lsu_pkg::*;
(
    input  logic              is_load,
    input  logic              sign_ext,
    input  acc_size_e         size,
    input  logic [LANE_W-1:0] lane,
    input  logic              half_hi,
    input  logic              misalign,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] load_val,
    output logic              re,
    output logic              wr
);

    logic [7:0]        lane_byte [LANES];
    logic [7:0]        sel_b;
    logic [HALF_W-1:0] sel_h;
    logic              go;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_byte[k] = rdata[8*k +: 8];
    end

    // Read request and write-back enable: aligned loads only.
    always_comb begin
        go = is_load & ~misalign;
        re = go;
        wr = go;
    end

    // Pick the byte and halfword candidates.
    always_comb begin
        sel_b = lane_byte[lane];
        sel_h = half_hi ? rdata[WORD_W-1:HALF_W] : rdata[HALF_W-1:0];
    end

    // Extend to the word; zero when no aligned load.
    always_comb begin
        load_val = '0;
        if (go) begin
            unique case (size)
                SZ_BYTE: load_val = {{(WORD_W-8){sign_ext & sel_b[7]}}, sel_b};
                SZ_HALF: load_val = {{(WORD_W-HALF_W){sign_ext & sel_h[HALF_W-1]}}, sel_h};
                default: load_val = rdata;
            endcase
        end
    end

endmodule

// File: rtl/lsu_align_unit.sv
`timescale 1ns/1ps
// Module: lsu_align_unit (top)
// Decodes a load/store instruction, forms the address, and steers bytes
// between register and memory under a static endianness select.
// Assumes a combinational memory read path; no state is held here.
module lsu_align_unit
    import lsu_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic [31:0] instr,
    input  logic [31:0] base_val,
    input  logic [31:0] src_val,
    input  logic [31:0] mem_rdata,
    input  logic        big_end,
    output logic [4:0]  base_idx,
    output logic [4:0]  data_idx,
    output logic [31:0] eff_addr,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_be,
    output logic        mem_we,
    output logic        mem_re,
    output logic [31:0] load_val,
    output logic        load_wr,
    output logic        misalign
);

    acc_ctl_t          ctl;
    logic [LANE_W-1:0] lane;
    logic              half_hi;
    logic              mis_raw;

    // Split the instruction into its fields.
    always_comb begin
        base_idx = instr[25:21];
        data_idx = instr[20:16];
    end

    lsu_decode u_dec (
        .opcode (instr[31:26]),
        .ctl    (ctl)
    );

    lsu_addr_gen #(.ADDR_W(WORD_W), .OFF_W(OFF_W)) u_addr (
        .base_val  (base_val),
        .offset    (instr[OFF_W-1:0]),
        .size      (ctl.size),
        .big_end   (big_end),
        .eff_addr  (eff_addr),
        .word_addr (mem_addr),
        .lane      (lane),
        .half_hi   (half_hi),
        .misalign  (mis_raw)
    );

    // Flag only applies to real memory operations.
    always_comb misalign = mis_raw & (ctl.is_load | ctl.is_store);

    lsu_store_lane u_st (
        .is_store (ctl.is_store),
        .size     (ctl.size),
        .lane     (lane),
        .half_hi  (half_hi),
        .misalign (misalign),
        .src_val  (src_val),
        .wdata    (mem_wdata),
        .be       (mem_be),
        .we       (mem_we)
    );

    lsu_load_lane u_ld (
        .is_load  (ctl.is_load),
        .sign_ext (ctl.sign_ext),
        .size     (ctl.size),
        .lane     (lane),
        .half_hi  (half_hi),
        .misalign (misalign),
        .rdata    (mem_rdata),
        .load_val (load_val),
        .re       (mem_re),
        .wr       (load_wr)
    );

endmodule

// File: rtl/lsu_align_chk.sv
`timescale 1ns/1ps
// Module: lsu_align_chk
// Checker bound to lsu_align_unit; decodes the opcode on its own and
// relates it to the enables, flags and result at the ports.
module lsu_align_chk (
    input logic [31:0] instr,
    input logic [3:0]  mem_be,
    input logic        mem_we,
    input logic        mem_re,
    input logic [31:0] load_val,
    input logic        load_wr,
    input logic        misalign
);

    logic [5:0] op;
    logic       is_mem;
    logic       is_byte;

    // Independent opcode classification.
    always_comb begin
        op      = instr[31:26];
        is_mem  = (op == 6'h20) || (op == 6'h24) || (op == 6'h21) || (op == 6'h25) ||
                  (op == 6'h23) || (op == 6'h28) || (op == 6'h29) || (op == 6'h2b);
        is_byte = (op == 6'h20) || (op == 6'h24) || (op == 6'h28);
    end

    // Port-level relations checked on every evaluation.
    always_comb begin
        a_r1_idle: assert (is_mem || (mem_be == 4'b0 && !mem_we && !mem_re &&
                                      !load_wr && load_val == 32'b0 && !misalign))
            else $error("R1 non-memory opcode produced activity");
        a_r1_excl: assert (!(mem_we && mem_re))
            else $error("R1 read and write together");
        a_r3_one_lane: assert (op != 6'h28 || $countones(mem_be) == 1)
            else $error("R3 byte store enable not one-hot");
        a_r4_half_pair: assert (op != 6'h29 || misalign || mem_be == 4'b0011 || mem_be == 4'b1100)
            else $error("R4 half store enables not a lane pair");
        a_r5_zero_ext: assert ((op != 6'h24 || load_val[31:8] == 24'b0) &&
                               (op != 6'h25 || load_val[31:16] == 16'b0))
            else $error("R5 unsigned load not zero-extended");
        a_r7_block: assert (!misalign || (mem_be == 4'b0 && !mem_we && !mem_re && !load_wr))
            else $error("R7 misaligned access not blocked");
        a_r7_byte_ok: assert (!is_byte || !misalign)
            else $error("R7 byte access flagged misaligned");
    end

endmodule

bind lsu_align_unit lsu_align_chk u_chk (
    .instr    (instr),
    .mem_be   (mem_be),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .load_val (load_val),
    .load_wr  (load_wr),
    .misalign (misalign)
);

// File: tb/sim_lsu_align_unit.sv
`timescale 1ns/1ps
// Bench for lsu_align_unit: a 16-word behavioural memory, a byte-addressed
// reference image, directed corner cases and seeded random traffic.
module sim_lsu_align_unit;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [31:0] instr = '0, base_val = '0, src_val = '0, mem_rdata;
    logic        big_end = 1'b0;
    logic [4:0]  base_idx, data_idx;
    logic [31:0] eff_addr, mem_addr, mem_wdata, load_val;
    logic [3:0]  mem_be;
    logic        mem_we, mem_re, load_wr, misalign;

    int tests = 0;
    int fails = 0;

    lsu_align_unit u0 (
        .instr(instr), .base_val(base_val), .src_val(src_val), .mem_rdata(mem_rdata),
        .big_end(big_end), .base_idx(base_idx), .data_idx(data_idx), .eff_addr(eff_addr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_we(mem_we),
        .mem_re(mem_re), .load_val(load_val), .load_wr(load_wr), .misalign(misalign)
    );

    // Behavioural word memory
    logic [31:0] tmem [16];
    logic [7:0]  refb [64];
    assign mem_rdata = tmem[mem_addr[5:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) tmem[i] <= '0;
        end else if (mem_we) begin
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) tmem[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int size_of(input logic [5:0] op);
        case (op)
            6'h20, 6'h24, 6'h28: return 1;
            6'h21, 6'h25, 6'h29: return 2;
            6'h23, 6'h2b:        return 4;
            default:             return 0;
        endcase
    endfunction

    function automatic bit is_ld(input logic [5:0] op);
        return op == 6'h20 || op == 6'h24 || op == 6'h21 || op == 6'h25 || op == 6'h23;
    endfunction

    function automatic bit is_st(input logic [5:0] op);
        return op == 6'h28 || op == 6'h29 || op == 6'h2b;
    endfunction

    function automatic logic [1:0] lane_of(input logic [31:0] a, input logic be);
        return be ? 2'd3 - a[1:0] : a[1:0];
    endfunction

    task automatic do_reset();
        instr = '0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) refb[i] = 8'h00;
    endtask

    // Drive one instruction; ea chosen, base back-computed from the offset.
    task automatic run_op(input logic [5:0] op, input logic [31:0] ea, input logic [15:0] off,
                          input logic [31:0] src, input logic [4:0] rs, input logic [4:0] rt);
        int n;
        bit mis, ld, st;
        logic [3:0]  e_be;
        logic [31:0] e_wd, e_lv, raw;
        n  = size_of(op);
        ld = is_ld(op);
        st = is_st(op);
        mis = (n == 2 && ea[0]) || (n == 4 && ea[1:0] != 2'b00);
        @(negedge clk);
        instr    = {op, rs, rt, off};
        base_val = ea - {{16{off[15]}}, off};
        src_val  = src;
        #1;
        e_be = '0;
        if (st && !mis)
            for (int i = 0; i < n; i++) e_be[lane_of(ea + 32'(i), big_end)] = 1'b1;
        e_wd = (n == 1) ? {4{src[7:0]}} : (n == 2) ? {2{src[15:0]}} : src;
        raw = '0;
        if (ld && !mis)
            for (int i = 0; i < n; i++) begin
                if (big_end) raw = (raw << 8) | 32'(refb[(ea[5:0] + 6'(i))]);
                else         raw[8*i +: 8] = refb[(ea[5:0] + 6'(i))];
            end
        e_lv = raw;
        if (ld && !mis && op == 6'h20) e_lv = {{24{raw[7]}}, raw[7:0]};
        if (ld && !mis && op == 6'h21) e_lv = {{16{raw[15]}}, raw[15:0]};
        chk("R9 base_idx", 32'(base_idx), 32'(rs));
        chk("R9 data_idx", 32'(data_idx), 32'(rt));
        chk("R2 eff_addr", eff_addr, ea);
        chk("R2 mem_addr", mem_addr, {ea[31:2], 2'b00});
        chk("R7 misalign", 32'(misalign), 32'(mis));
        chk("R3/R4 mem_be", 32'(mem_be), 32'(e_be));
        chk("R4/R1 mem_we", 32'(mem_we), 32'(st && !mis));
        chk("R6/R1 mem_re", 32'(mem_re), 32'(ld && !mis));
        chk("R6/R1 load_wr", 32'(load_wr), 32'(ld && !mis));
        chk("R5/R6/R8 load_val", load_val, e_lv);
        if (st && !mis) begin
            chk("R3/R4 mem_wdata", mem_wdata, e_wd);
            for (int i = 0; i < n; i++)
                refb[(ea[5:0] + 6'(i))] = big_end ? src[8*(n-1-i) +: 8] : src[8*i +: 8];
        end
    endtask

    task automatic random_phase(input int count);
        logic [5:0] ops [8];
        logic [5:0] op;
        ops = '{6'h20, 6'h24, 6'h21, 6'h25, 6'h23, 6'h28, 6'h29, 6'h2b};
        for (int i = 0; i < count; i++) begin
            op = ($urandom % 10 == 0) ? 6'($urandom) : ops[$urandom % 8];
            run_op(op, 32'($urandom % 64), 16'($urandom), $urandom,
                   5'($urandom), 5'($urandom));
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        // R1: reset state, opcode 0 is not a memory op
        #1;
        chk("R1 idle be", 32'(mem_be), 32'h0);
        chk("R1 idle we/re/wr", {29'b0, mem_we, mem_re, load_wr}, 32'h0);
        chk("R1 idle load_val", load_val, 32'h0);

        // Little-endian directed cases
        big_end = 1'b0;
        run_op(6'h2b, 32'd8, 16'd8, 32'h5, 5'd0, 5'd5);
        run_op(6'h20, 32'd8, 16'd8, 32'h0, 5'd0, 5'd6);
        chk("R8 little LB @8", load_val, 32'h5);
        run_op(6'h20, 32'd11, 16'd11, 32'h0, 5'd0, 5'd7);
        chk("R8 little LB @11", load_val, 32'h0);
        run_op(6'h28, 32'd21, 16'hFFF0, 32'h1234_5680, 5'd3, 5'd4);
        run_op(6'h20, 32'd21, 16'hFFF0, 32'h0, 5'd3, 5'd4);
        chk("R5 LB sign", load_val, 32'hFFFF_FF80);
        run_op(6'h24, 32'd21, 16'd1, 32'h0, 5'd3, 5'd4);
        chk("R5 LBU zero", load_val, 32'h0000_0080);
        run_op(6'h29, 32'd30, 16'h8000, 32'hABCD_8001, 5'd1, 5'd2);
        run_op(6'h21, 32'd30, 16'd2, 32'h0, 5'd1, 5'd2);
        chk("R5 LH sign", load_val, 32'hFFFF_8001);
        run_op(6'h25, 32'd30, 16'd2, 32'h0, 5'd1, 5'd2);
        chk("R5 LHU zero", load_val, 32'h0000_8001);
        run_op(6'h21, 32'd5, 16'd0, 32'h0, 5'd1, 5'd2);
        chk("R7 LH odd", 32'(misalign), 32'h1);
        run_op(6'h2b, 32'd6, 16'd0, 32'hFFFF_FFFF, 5'd1, 5'd2);
        chk("R7 SW blocked", 32'(mem_we), 32'h0);
        run_op(6'h29, 32'd3, 16'd0, 32'hFFFF, 5'd1, 5'd2);
        run_op(6'h23, 32'd2, 16'd0, 32'h0, 5'd1, 5'd2);
        run_op(6'h0F, 32'd8, 16'd8, 32'hFFFF_FFFF, 5'd9, 5'd9);
        chk("R1 non-mem load_val", load_val, 32'h0);
        run_op(6'h22, 32'd8, 16'd8, 32'hFFFF_FFFF, 5'd9, 5'd9);
        chk("R1 non-mem be", 32'(mem_be), 32'h0);
        random_phase(1500);

        // Big-endian: fresh memory
        do_reset();
        big_end = 1'b1;
        run_op(6'h2b, 32'd8, 16'd8, 32'h5, 5'd0, 5'd5);
        run_op(6'h20, 32'd11, 16'd11, 32'h0, 5'd0, 5'd7);
        chk("R8 big LB @11", load_val, 32'h5);
        run_op(6'h20, 32'd8, 16'd8, 32'h0, 5'd0, 5'd6);
        chk("R8 big LB @8", load_val, 32'h0);
        run_op(6'h28, 32'd2, 16'd2, 32'h77, 5'd0, 5'd1);
        chk("R3 big SB lane", 32'(mem_be), 32'h2);
        run_op(6'h20, 32'd2, 16'd2, 32'h0, 5'd0, 5'd1);
        chk("R8 big SB/LB", load_val, 32'h77);
        run_op(6'h29, 32'd0, 16'd0, 32'h1234, 5'd0, 5'd1);
        chk("R4 big SH @0", 32'(mem_be), 32'hC);
        run_op(6'h23, 32'd8, 16'd8, 32'h0, 5'd0, 5'd1);
        chk("R6 big LW", load_val, 32'h5);
        random_phase(1500);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule